// File: doc/BRIEF.md
# Hot basic block profiler

This block watches the stream of committed program-counter values and finds the basic blocks that run most often. Each strobed PC is compared with the one before it. Any value other than the next sequential instruction address is treated as the target of a taken branch or jump. That target is looked up in a small fully associative table of block start addresses, and each table entry carries a saturating execution counter.

A hit raises the counter of the matching entry. A miss claims a table slot for the new address, with its count starting at one. When the table is full, the entry with the smallest count is replaced. Each entry drives a hot flag when its count exceeds a programmable threshold. A read port lets software walk the table and dump its contents. A clear input empties the whole table in a single cycle.

Top module: `hbb_profiler`

## Requirements
- R1: After reset every entry is invalid and all hot flags are 0. No previous PC is held, so the first strobed PC after reset is only recorded and never touches the table.
- R2: A strobed PC equal to the previous PC plus 4 (the instruction size in bytes) leaves the table unchanged. A cycle with `pc_valid` low leaves both the table and the recorded previous PC unchanged.
- R3: Any other strobed PC counts as a taken-branch target and is looked up in the table. This covers a forward jump, a backward jump, a step back of exactly 4 and a repeat of the same PC.
- R4: A target that matches a valid entry raises that entry's count by one, visible on the read port after the next rising clock edge.
- R5: A target that matches no entry is written into the lowest-numbered invalid entry, with that entry's count set to 1, after the next rising clock edge.
- R6: On a miss with all entries valid, the entry with the smallest count is replaced, and ties go to the lowest index.
- R7: Counts are 16 bits wide and stay at 65535 once they reach it.
- R8: `hot[i]` is 1 exactly when entry i is valid and its count is strictly greater than `threshold`. It follows a change of `threshold` without a clock edge.
- R9: `clear` invalidates every entry at the next rising edge and takes priority over a strobe in the same cycle. The PC of that strobe is still recorded as the previous PC.
- R10: The read port is combinational. `rd_idx` selects entry i, and `rd_valid`, `rd_addr` and `rd_count` return its valid bit, start address and count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_valid | input | 1 | Committed-PC strobe |
| pc | input | 32 | Committed PC value |
| clear | input | 1 | Invalidate all entries |
| threshold | input | 16 | Hotness threshold |
| hot | output | 16 | Per-entry hot flag, bit i for entry i |
| rd_idx | input | 4 | Entry to read |
| rd_valid | output | 1 | Valid bit of the selected entry |
| rd_addr | output | 32 | Start address of the selected entry |
| rd_count | output | 16 | Execution count of the selected entry |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a clear and a strobe that is itself a taken branch. The bench raises both together and expects an empty table and no hot flags. The following sequential PC must then leave the table untouched, which proves the strobe was still recorded as the previous PC. The second pair is a hit and counter saturation: a PC that repeats itself is held for more than 65535 strobes, and the count is expected to sit at its maximum while the hot flag follows threshold values on either side of it.

// File: rtl/hbb_prof_pkg.sv
package hbb_prof_pkg;

    // Size of one instruction in bytes; a sequential step advances by this.
    localparam int unsigned INSN_BYTES = 4;

    // Action taken on the table in the current cycle.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_HIT   = 2'd1,
        ACT_ALLOC = 2'd2,
        ACT_CLEAR = 2'd3
    } tbl_act_e;

    // Saturating increment on a counter of up to 32 bits, width given.
    function automatic logic [31:0] sat_inc(input logic [31:0] val,
                                            input logic [31:0] max_val);
        return (val == max_val) ? max_val : val + 32'd1;
    endfunction

endpackage

// File: rtl/hbb_step_detect.sv
module hbb_step_detect
    import hbb_prof_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_valid,
    input  logic [PC_W-1:0] pc,
    output logic            taken
);

    logic [PC_W-1:0] last_pc;
    logic            last_ok;
    logic [PC_W-1:0] seq_pc;

    assign seq_pc = last_pc + PC_W'(INSN_BYTES);

    // Anything but the next sequential address is a redirect.
    assign taken = pc_valid && last_ok && (pc != seq_pc);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pc <= '0;
            last_ok <= 1'b0;
        end else if (pc_valid) begin
            last_pc <= pc;
            last_ok <= 1'b1;
        end
    end

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst)
        pc_valid |=> (last_pc == $past(pc)) && last_ok); // R2
    AST_PREV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !pc_valid |=> $stable(last_pc)); // R2

endmodule

// File: rtl/hbb_match.sv
module hbb_match #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned PC_W    = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ENTRIES-1:0]           ent_valid,
    input  logic [ENTRIES-1:0][PC_W-1:0] ent_addr,
    input  logic [PC_W-1:0]              key,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_addr[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

    // Allocation only on a miss keeps stored addresses unique.
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R4

endmodule

// File: rtl/hbb_victim.sv
module hbb_victim #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt,
    output logic [IDX_W-1:0]              victim_idx
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] min_idx;
    logic [CNT_W-1:0] min_cnt;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // Strict less-than keeps the lowest index on a tie.
    always_comb begin
        min_idx = '0;
        min_cnt = ent_cnt[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (ent_cnt[i] < min_cnt) begin
                min_cnt = ent_cnt[i];
                min_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx = free_found ? free_idx : min_idx;

    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (rst)
        (ent_valid != '1) |-> !ent_valid[victim_idx]); // R5
    AST_VICTIM_NOT_LARGER: assert property (@(posedge clk) disable iff (rst)
        (ent_valid == '1) |-> (ent_cnt[victim_idx] <= ent_cnt[0])); // R6

endmodule

// File: rtl/hbb_profiler.sv
module hbb_profiler
    import hbb_prof_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pc_valid,
    input  logic [PC_W-1:0]    pc,
    input  logic               clear,
    input  logic [CNT_W-1:0]   threshold,
    output logic [ENTRIES-1:0] hot,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [PC_W-1:0]    rd_addr,
    output logic [CNT_W-1:0]   rd_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][PC_W-1:0]  ent_addr;
    logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt;

    logic             taken;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [CNT_W-1:0] hit_cnt;
    logic [CNT_W-1:0] hit_cnt_nxt;
    tbl_act_e         act;

    hbb_step_detect #(.PC_W(PC_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .pc_valid (pc_valid),
        .pc       (pc),
        .taken    (taken)
    );

    hbb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .key       (pc),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    hbb_victim #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .ent_valid  (ent_valid),
        .ent_cnt    (ent_cnt),
        .victim_idx (victim_idx)
    );

    assign hit_cnt     = ent_cnt[hit_idx];
    assign hit_cnt_nxt = CNT_W'(sat_inc(32'(hit_cnt), 32'(CNT_MAX)));

    always_comb begin
        if (clear)      act = ACT_CLEAR;
        else if (!taken) act = ACT_IDLE;
        else if (hit)   act = ACT_HIT;
        else            act = ACT_ALLOC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            ent_addr  <= '0;
            ent_cnt   <= '0;
        end else begin
            case (act)
                ACT_CLEAR: ent_valid <= '0;
                ACT_HIT:   ent_cnt[hit_idx] <= hit_cnt_nxt;
                ACT_ALLOC: begin
                    ent_valid[victim_idx] <= 1'b1;
                    ent_addr[victim_idx]  <= pc;
                    ent_cnt[victim_idx]   <= CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_hot
        assign hot[g] = ent_valid[g] && (ent_cnt[g] > threshold);
    end

    assign rd_valid = ent_valid[rd_idx];
    assign rd_addr  = ent_addr[rd_idx];
    assign rd_count = ent_cnt[rd_idx];

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!clear && !taken) |=> ($stable(ent_valid) && $stable(ent_addr) && $stable(ent_cnt))); // R2
    AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HIT) |=> (ent_cnt[$past(hit_idx)] ==
            (($past(hit_cnt) == CNT_MAX) ? CNT_MAX : $past(hit_cnt) + CNT_W'(1)))); // R4
    AST_ALLOC_FILL: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ALLOC) |=> (ent_valid[$past(victim_idx)] &&
            (ent_addr[$past(victim_idx)] == $past(pc)) &&
            (ent_cnt[$past(victim_idx)] == CNT_W'(1)))); // R5
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ent_valid == '0)); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HIT && hit_cnt == CNT_MAX) |=> (ent_cnt[$past(hit_idx)] == CNT_MAX)); // R7

endmodule

// File: tb/hbb_profiler_bench.sv
module hbb_profiler_bench;

    typedef struct packed {
        logic        clr;
        logic        pv;
        logic [31:0] pc;
        logic [3:0]  idx;
        logic        ev;
        logic [31:0] ea;
        logic [15:0] ec;
        logic [15:0] eh;
        logic [23:0] tag;
    } vec_t;

    // Threshold is 2 throughout the table walk.
    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 32'h0000_0100, 4'd0, 1'b0, 32'h0,          16'd0, 16'h0000, "R1"},
        '{1'b0, 1'b1, 32'h0000_0104, 4'd0, 1'b0, 32'h0,          16'd0, 16'h0000, "R2"},
        '{1'b0, 1'b1, 32'h0000_0200, 4'd0, 1'b1, 32'h0000_0200, 16'd1, 16'h0000, "R5"},
        '{1'b0, 1'b1, 32'h0000_0204, 4'd0, 1'b1, 32'h0000_0200, 16'd1, 16'h0000, "R2"},
        '{1'b0, 1'b1, 32'h0000_0100, 4'd1, 1'b1, 32'h0000_0100, 16'd1, 16'h0000, "R3"},
        '{1'b0, 1'b1, 32'h0000_0200, 4'd0, 1'b1, 32'h0000_0200, 16'd2, 16'h0000, "R4"},
        '{1'b0, 1'b1, 32'h0000_0200, 4'd0, 1'b1, 32'h0000_0200, 16'd3, 16'h0001, "R8"},
        '{1'b0, 1'b1, 32'h0000_01FC, 4'd2, 1'b1, 32'h0000_01FC, 16'd1, 16'h0001, "R3"},
        '{1'b0, 1'b1, 32'h0000_0200, 4'd0, 1'b1, 32'h0000_0200, 16'd3, 16'h0001, "R2"},
        '{1'b0, 1'b0, 32'h0000_0900, 4'd0, 1'b1, 32'h0000_0200, 16'd3, 16'h0001, "R2"},
        '{1'b0, 1'b1, 32'h0000_0204, 4'd0, 1'b1, 32'h0000_0200, 16'd3, 16'h0001, "R2"}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        pc_valid;
    logic [31:0] pc;
    logic        clear;
    logic [15:0] threshold;
    logic [15:0] hot;
    logic [3:0]  rd_idx;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic [15:0] rd_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hbb_profiler u_hbb_profiler (
        .clk       (clk),
        .rst       (rst),
        .pc_valid  (pc_valid),
        .pc        (pc),
        .clear     (clear),
        .threshold (threshold),
        .hot       (hot),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_count  (rd_count)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, actual, expected);
        end
    endtask

    task automatic strobe(input logic c, input logic v, input logic [31:0] p);
        @(negedge clk);
        clear    = c;
        pc_valid = v;
        pc       = p;
        @(posedge clk);
        #1;
        clear    = 1'b0;
        pc_valid = 1'b0;
    endtask

    task automatic look(input string tag, input logic [3:0] i, input logic ev,
                        input logic [31:0] ea, input logic [15:0] ec);
        rd_idx = i;
        #1;
        chk(tag, "rd_valid", 32'(rd_valid), 32'(ev));
        if (ev) begin
            chk(tag, "rd_addr", rd_addr, ea);
            chk(tag, "rd_count", 32'(rd_count), 32'(ec));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        pc_valid  = 1'b0;
        pc        = '0;
        clear     = 1'b0;
        threshold = 16'd2;
        rd_idx    = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 / R10: empty table after reset
        for (int i = 0; i < 16; i++) look("R1", 4'(i), 1'b0, 32'h0, 16'd0);
        chk("R1", "hot", 32'(hot), 32'h0);

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            strobe(VECS[k].clr, VECS[k].pv, VECS[k].pc);
            look(string'(VECS[k].tag), VECS[k].idx, VECS[k].ev, VECS[k].ea, VECS[k].ec);
            chk(string'(VECS[k].tag), "hot", 32'(hot), 32'(VECS[k].eh));
        end

        // R9: clear alone
        strobe(1'b1, 1'b0, 32'h0);
        chk("R9", "hot", 32'(hot), 32'h0);
        look("R9", 4'd0, 1'b0, 32'h0, 16'd0);

        // R5: fill all slots in order
        for (int i = 0; i < 16; i++) strobe(1'b0, 1'b1, 32'h1000 + 32'(i) * 32'h100);
        look("R5", 4'd15, 1'b1, 32'h1F00, 16'd1);
        look("R10", 4'd7, 1'b1, 32'h1700, 16'd1);
        strobe(1'b0, 1'b1, 32'h1000);
        strobe(1'b0, 1'b1, 32'h1100);
        look("R4", 4'd1, 1'b1, 32'h1100, 16'd2);

        // R6: full table, smallest count, lowest index wins
        strobe(1'b0, 1'b1, 32'h9000);
        look("R6", 4'd2, 1'b1, 32'h9000, 16'd1);
        look("R6", 4'd3, 1'b1, 32'h1300, 16'd1);
        strobe(1'b0, 1'b1, 32'hA000);
        look("R6", 4'd2, 1'b1, 32'hA000, 16'd1);
        look("R6", 4'd0, 1'b1, 32'h1000, 16'd2);

        // R7: self-repeating PC held past saturation
        @(negedge clk);
        pc_valid = 1'b1;
        pc       = 32'h5000;
        repeat (65540) @(posedge clk);
        #1;
        pc_valid = 1'b0;
        look("R7", 4'd2, 1'b1, 32'h5000, 16'hFFFF);
        chk("R8", "hot", 32'(hot), 32'h0004);
        threshold = 16'hFFFE;
        #1;
        chk("R8", "hot_thr_fffe", 32'(hot), 32'h0004);
        threshold = 16'hFFFF;
        #1;
        chk("R8", "hot_thr_ffff", 32'(hot), 32'h0000);
        threshold = 16'd1;
        #1;
        chk("R8", "hot_thr_1", 32'(hot), 32'h0007);
        threshold = 16'd2;

        // R9: clear together with a branching strobe
        strobe(1'b1, 1'b1, 32'h6000);
        chk("R9", "hot", 32'(hot), 32'h0);
        look("R9", 4'd2, 1'b0, 32'h0, 16'd0);
        strobe(1'b0, 1'b1, 32'h6004);
        look("R9", 4'd0, 1'b0, 32'h0, 16'd0);
        strobe(1'b0, 1'b1, 32'h7000);
        look("R5", 4'd0, 1'b1, 32'h7000, 16'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule